// File: doc/BRIEF.md
# Long-Word UART Receive Deserializer

This block turns an asynchronous serial line into parallel characters. It runs from a system clock and is advanced by a sampling enable, `tick16`, which pulses at sixteen times the bit rate. A character opens with a low start bit. Then come 5 to 14 data bits, least significant bit first. An optional parity bit follows, and the frame closes with one or two high stop bits. Every received character produces a one-cycle strobe. The strobe carries the word, zero-extended to 14 bits, and its status flags.

Beyond plain reception, the block tells a line held low apart from a corrupted character. A frame whose data, parity and stop positions all read low is taken as a break. The block then measures the break in whole character times and reports that length once the line goes high again. After every character or break, the block watches for a quiet line and raises a single idle pulse when the line has stayed high for one full character time.

Configuration inputs are expected to stay stable while a frame is on the line. Storage of the received words is left to the surrounding logic.

Top module: `lw_uart_rx`

## Requirements
- R1: Data bits are assembled least significant bit first into `rx_word`. Unused upper bits read zero. `rx_valid` is high for exactly one cycle per character.
- R2: `cfg_len` gives the data length. A value below 5 is treated as 5 and a value above 14 is treated as 14.
- R3: `cfg_par` encodings are 2'b00 no parity, 2'b01 even, 2'b10 odd and 2'b11 no parity. `rx_perr` is set when the data bits and the received parity bit disagree with the selected mode.
- R4: `cfg_two_stop` = 1 expects two stop bits and 0 expects one. `rx_ferr` is set when any expected stop bit is sampled low, unless R6 applies.
- R5: A low level in idle is confirmed at the eighth tick. If the line reads high there, the event is dropped and nothing is reported.
- R6: A frame that reads low in every data, parity and stop position is a break. No word is reported for it. When the line returns high, one strobe is issued with `rx_brk` = 1, word 0 and both error flags clear. `rx_brk_len` then holds 1 plus the number of further complete character times the line stayed low, saturating. A zero word with a high stop bit, or with a high parity bit, is an ordinary character.
- R7: `idle_pulse` fires once after the line has been high for one character time (start, data, parity and stop bits, times 16 ticks), counted from the end of a character or break. It never fires before the first character after reset.
- R8: Any low sample during the idle wait restarts the wait, so the pulse comes one full character time after the line last went high.
- R9: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | Sampling enable at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high |
| cfg_len | input | 4 | Data bits per character (clamped to 5..14) |
| cfg_par | input | 2 | Parity mode: 00 none, 01 even, 10 odd, 11 none |
| cfg_two_stop | input | 1 | 1 = two stop bits, 0 = one |
| rx_valid | output | 1 | One-cycle strobe for a character or a finished break |
| rx_word | output | 14 | Received data, zero-extended |
| rx_perr | output | 1 | Parity error for this character |
| rx_ferr | output | 1 | Framing error for this character |
| rx_brk | output | 1 | Strobe reports a break |
| rx_brk_len | output | 8 | Break length in character times |
| idle_pulse | output | 1 | One-cycle idle-line indication |

## Verification
The two functions that can collide are idle detection and start-edge validation. Both are driven by the same line sample, so a short low glitch that arrives while the idle wait is running must both be rejected as a start and restart the idle wait. The bench places a four-cycle glitch inside the idle window after a character. It confirms that the expected idle item is still pending a little less than one character time later, and that the item has been consumed once a full character time has passed. A framing-error frame whose low stop bit runs straight into a rejected start edge exercises the same overlap on the character side.

// File: rtl/lw_uart_rx_pkg.sv
// Shared types for the long-word UART receiver.
package lw_uart_rx_pkg;

    // Frame tracker states, one per bit class plus break hold.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_BRK
    } rx_state_e;

endpackage

// File: rtl/lw_uart_rx_sync.sv
// Line synchronizer: brings the asynchronous serial input into the clock
// domain through a chain of flops. Resets to the idle (high) level.
// Assumes STAGES >= 2.
module lw_uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    // Shift the raw line level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/lw_uart_rx_frame.sv
// Frame tracker: follows one character bit by bit on the 16x tick. It
// validates the start bit, gathers data and parity, checks stop bits and
// separates breaks from framing errors. Results are registered one-cycle
// strobes. Assumes the configuration is stable during a frame.
module lw_uart_rx_frame
    import lw_uart_rx_pkg::*;
#(
    parameter int MAX_BITS = 14,
    parameter int OVS      = 16,
    parameter int BRK_W    = 8,
    localparam int LEN_W   = $clog2(MAX_BITS + 1),
    localparam int TCW     = $clog2((MAX_BITS + 4) * OVS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                line,
    input  logic [LEN_W-1:0]    len_eff,
    input  logic                par_on,
    input  logic                par_odd,
    input  logic                two_stop,
    input  logic [TCW-1:0]      frame_ticks,
    output logic                in_idle,
    output logic                o_valid,
    output logic [MAX_BITS-1:0] o_word,
    output logic                o_perr,
    output logic                o_ferr,
    output logic                o_brk,
    output logic [BRK_W-1:0]    o_brk_len
);

    localparam int OVS_W = $clog2(OVS);
    localparam logic [OVS_W-1:0] MID  = OVS_W'(OVS / 2 - 1);
    localparam logic [OVS_W-1:0] LAST = OVS_W'(OVS - 1);
    localparam logic [BRK_W-1:0] BRK_MAX = '1;

    rx_state_e            state;
    logic [OVS_W-1:0]     cnt;
    logic [LEN_W-1:0]     bidx;
    logic [MAX_BITS-1:0]  acc;
    logic                 par_bit;
    logic                 any_one;
    logic                 stop_idx;
    logic                 stop_hi_seen;
    logic                 stop_lo_seen;
    logic [TCW-1:0]       bcnt;
    logic [BRK_W-1:0]     blen;
    logic                 at_mid;
    logic                 at_last;
    logic                 last_stop;

    assign at_mid    = (cnt == MID);
    assign at_last   = (cnt == LAST);
    assign last_stop = stop_idx || !two_stop;
    assign in_idle   = (state == ST_IDLE);

    // Advance the frame state machine and register the result strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            cnt          <= '0;
            bidx         <= '0;
            acc          <= '0;
            par_bit      <= 1'b0;
            any_one      <= 1'b0;
            stop_idx     <= 1'b0;
            stop_hi_seen <= 1'b0;
            stop_lo_seen <= 1'b0;
            bcnt         <= '0;
            blen         <= '0;
            o_valid      <= 1'b0;
            o_word       <= '0;
            o_perr       <= 1'b0;
            o_ferr       <= 1'b0;
            o_brk        <= 1'b0;
            o_brk_len    <= '0;
        end else begin
            o_valid <= 1'b0;
            if (tick) begin
                cnt <= at_last ? '0 : cnt + OVS_W'(1);
                case (state)
                    ST_IDLE: begin
                        cnt <= '0;
                        if (!line) state <= ST_START;
                    end
                    ST_START: begin
                        if (at_mid && line) begin
                            state <= ST_IDLE;
                        end else if (at_last) begin
                            state        <= ST_DATA;
                            bidx         <= '0;
                            acc          <= '0;
                            par_bit      <= 1'b0;
                            any_one      <= 1'b0;
                            stop_idx     <= 1'b0;
                            stop_hi_seen <= 1'b0;
                            stop_lo_seen <= 1'b0;
                        end
                    end
                    ST_DATA: begin
                        if (at_mid) begin
                            acc[bidx] <= line;
                            if (line) any_one <= 1'b1;
                        end
                        if (at_last) begin
                            if (bidx == len_eff - LEN_W'(1))
                                state <= par_on ? ST_PAR : ST_STOP;
                            else
                                bidx <= bidx + LEN_W'(1);
                        end
                    end
                    ST_PAR: begin
                        if (at_mid) begin
                            par_bit <= line;
                            if (line) any_one <= 1'b1;
                        end
                        if (at_last) state <= ST_STOP;
                    end
                    ST_STOP: begin
                        if (at_mid && last_stop) begin
                            if (!any_one && !line && !stop_hi_seen) begin
                                state <= ST_BRK;
                                bcnt  <= '0;
                                blen  <= BRK_W'(1);
                            end else begin
                                state     <= ST_IDLE;
                                o_valid   <= 1'b1;
                                o_word    <= acc;
                                o_perr    <= par_on & ((^acc) ^ par_bit ^ par_odd);
                                o_ferr    <= !line || stop_lo_seen;
                                o_brk     <= 1'b0;
                                o_brk_len <= '0;
                            end
                        end else if (at_mid) begin
                            if (line) stop_hi_seen <= 1'b1;
                            else      stop_lo_seen <= 1'b1;
                        end
                        if (at_last) stop_idx <= 1'b1;
                    end
                    ST_BRK: begin
                        if (line) begin
                            state     <= ST_IDLE;
                            o_valid   <= 1'b1;
                            o_word    <= '0;
                            o_perr    <= 1'b0;
                            o_ferr    <= 1'b0;
                            o_brk     <= 1'b1;
                            o_brk_len <= blen;
                        end else if (bcnt == frame_ticks - TCW'(1)) begin
                            bcnt <= '0;
                            if (blen != BRK_MAX) blen <= blen + BRK_W'(1);
                        end else begin
                            bcnt <= bcnt + TCW'(1);
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R1: a character strobe lasts a single cycle.
    a_r1_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        o_valid |=> !o_valid);

    // R1: no data bit above the configured length is ever reported.
    a_r1_word_fits: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && !o_brk) |-> ((o_word >> len_eff) == '0));

    // R6: a break report carries no word and no error flags.
    a_r6_brk_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && o_brk) |-> (o_word == '0 && !o_perr && !o_ferr));

    // R6: a break is at least one character time long.
    a_r6_brk_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && o_brk) |-> (o_brk_len != '0));

endmodule

// File: rtl/lw_uart_rx_idle.sv
// Idle watcher: after each character or break it counts ticks of a high
// line while the frame tracker rests. One character time of quiet yields a
// single idle pulse. Any low sample or a busy tracker restarts the count.
module lw_uart_rx_idle #(
    parameter int TCW = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           line,
    input  logic           in_idle,
    input  logic           done,
    input  logic [TCW-1:0] frame_ticks,
    output logic           idle_pulse
);

    logic           armed;
    logic [TCW-1:0] qcnt;

    // Arm on each finished frame; count quiet ticks; fire once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed      <= 1'b0;
            qcnt       <= '0;
            idle_pulse <= 1'b0;
        end else begin
            idle_pulse <= 1'b0;
            if (done) begin
                armed <= 1'b1;
                qcnt  <= '0;
            end else if (tick) begin
                if (!in_idle || !line) begin
                    qcnt <= '0;
                end else if (armed) begin
                    if (qcnt == frame_ticks - TCW'(1)) begin
                        idle_pulse <= 1'b1;
                        armed      <= 1'b0;
                        qcnt       <= '0;
                    end else begin
                        qcnt <= qcnt + TCW'(1);
                    end
                end
            end
        end
    end

    // R7: the idle indication is a single-cycle pulse.
    a_r7_idle_single: assert property (@(posedge clk) disable iff (!rst_n)
        idle_pulse |=> !idle_pulse);

    // R8: a low sample on a tick never completes the idle wait.
    a_r8_low_blocks_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !line) |=> !idle_pulse);

endmodule

// File: rtl/lw_uart_rx.sv
// Long-word UART receiver top. Synchronizes the line, decodes the
// configuration (length clamp, parity mode, frame time) and joins the frame
// tracker to the idle watcher. Assumes tick16 pulses at 16x the bit rate.
module lw_uart_rx #(
    parameter int MAX_BITS = 14,
    parameter int MIN_BITS = 5,
    parameter int OVS      = 16,
    parameter int BRK_W    = 8,
    parameter int SYNC_N   = 2,
    localparam int LEN_W   = $clog2(MAX_BITS + 1),
    localparam int TCW     = $clog2((MAX_BITS + 4) * OVS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick16,
    input  logic                rxd,
    input  logic [LEN_W-1:0]    cfg_len,
    input  logic [1:0]          cfg_par,
    input  logic                cfg_two_stop,
    output logic                rx_valid,
    output logic [MAX_BITS-1:0] rx_word,
    output logic                rx_perr,
    output logic                rx_ferr,
    output logic                rx_brk,
    output logic [BRK_W-1:0]    rx_brk_len,
    output logic                idle_pulse
);

    logic             line;
    logic             in_idle;
    logic [LEN_W-1:0] len_eff;
    logic             par_on;
    logic             par_odd;
    logic [TCW-1:0]   frame_bits;
    logic [TCW-1:0]   frame_ticks;

    // Clamp length, decode parity mode and size one character time.
    always_comb begin
        if (cfg_len < LEN_W'(MIN_BITS))      len_eff = LEN_W'(MIN_BITS);
        else if (cfg_len > LEN_W'(MAX_BITS)) len_eff = LEN_W'(MAX_BITS);
        else                                 len_eff = cfg_len;
        par_on      = (cfg_par == 2'b01) || (cfg_par == 2'b10);
        par_odd     = (cfg_par == 2'b10);
        frame_bits  = TCW'(len_eff) + TCW'(par_on) + TCW'(cfg_two_stop) + TCW'(2);
        frame_ticks = frame_bits * TCW'(OVS);
    end

    lw_uart_rx_sync #(.STAGES(SYNC_N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rxd),
        .q     (line)
    );

    lw_uart_rx_frame #(
        .MAX_BITS (MAX_BITS),
        .OVS      (OVS),
        .BRK_W    (BRK_W)
    ) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick16),
        .line        (line),
        .len_eff     (len_eff),
        .par_on      (par_on),
        .par_odd     (par_odd),
        .two_stop    (cfg_two_stop),
        .frame_ticks (frame_ticks),
        .in_idle     (in_idle),
        .o_valid     (rx_valid),
        .o_word      (rx_word),
        .o_perr      (rx_perr),
        .o_ferr      (rx_ferr),
        .o_brk       (rx_brk),
        .o_brk_len   (rx_brk_len)
    );

    lw_uart_rx_idle #(.TCW(TCW)) u_idle (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick16),
        .line        (line),
        .in_idle     (in_idle),
        .done        (rx_valid),
        .frame_ticks (frame_ticks),
        .idle_pulse  (idle_pulse)
    );

    // R7: an idle pulse never shares a cycle with a character strobe.
    a_r7_idle_apart: assert property (@(posedge clk) disable iff (!rst_n)
        idle_pulse |-> !rx_valid);

endmodule

// File: tb/lw_uart_rx_test.sv
// Scoreboard bench: driver tasks queue expected results, a monitor pops
// and compares them as strobes and idle pulses appear.
module lw_uart_rx_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick16 = 1'b1;
    logic        rxd = 1'b1;
    logic [3:0]  cfg_len = 4'd8;
    logic [1:0]  cfg_par = 2'b00;
    logic        cfg_two_stop = 1'b0;
    logic        rx_valid;
    logic [13:0] rx_word;
    logic        rx_perr;
    logic        rx_ferr;
    logic        rx_brk;
    logic [7:0]  rx_brk_len;
    logic        idle_pulse;

    typedef struct {
        bit          is_idle;
        logic [13:0] word;
        logic        perr;
        logic        ferr;
        logic        brk;
        logic [7:0]  blen;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   errors = 0;
    int   events = 0;

    always #2.5 clk = ~clk;

    lw_uart_rx uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick16       (tick16),
        .rxd          (rxd),
        .cfg_len      (cfg_len),
        .cfg_par      (cfg_par),
        .cfg_two_stop (cfg_two_stop),
        .rx_valid     (rx_valid),
        .rx_word      (rx_word),
        .rx_perr      (rx_perr),
        .rx_ferr      (rx_ferr),
        .rx_brk       (rx_brk),
        .rx_brk_len   (rx_brk_len),
        .idle_pulse   (idle_pulse)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic exp_char(input logic [13:0] w, input logic pe, input logic fe, input string tag);
        exp_t e;
        e.is_idle = 0; e.word = w; e.perr = pe; e.ferr = fe; e.brk = 0; e.blen = 0; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic exp_brk(input logic [7:0] n, input string tag);
        exp_t e;
        e.is_idle = 0; e.word = 0; e.perr = 0; e.ferr = 0; e.brk = 1; e.blen = n; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic exp_idle(input string tag);
        exp_t e;
        e.is_idle = 1; e.word = 0; e.perr = 0; e.ferr = 0; e.brk = 0; e.blen = 0; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic drive(input logic v, input int n);
        rxd = v;
        repeat (n) @(negedge clk);
    endtask

    // pm: 0 none, 1 even, 2 odd
    task automatic send(input logic [13:0] d, input int n, input int pm,
                        input bit two, input bit pflip, input bit bad_stop);
        logic p;
        drive(1'b0, 16);
        for (int i = 0; i < n; i++) drive(d[i], 16);
        if (pm != 0) begin
            p = ^d;
            if (pm == 2) p = ~p;
            drive(p ^ pflip, 16);
        end
        for (int s = 0; s < (two ? 2 : 1); s++) begin
            if (bad_stop && s == (two ? 1 : 0)) begin
                drive(1'b0, 14);
                drive(1'b1, 2);
            end else begin
                drive(1'b1, 16);
            end
        end
    endtask

    // Monitor: compare every strobe or idle pulse with the queue head.
    always @(negedge clk) begin
        if (rst_n && (rx_valid || idle_pulse)) begin
            exp_t e;
            events++;
            if (sb.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL unexpected event valid=%0b idle=%0b word=%0h expected=none",
                         rx_valid, idle_pulse, rx_word);
            end else begin
                e = sb.pop_front();
                if (e.is_idle) begin
                    check(idle_pulse && !rx_valid, e.tag, {rx_valid, idle_pulse}, 1);
                end else begin
                    check(rx_valid && !idle_pulse && rx_word == e.word && rx_perr == e.perr &&
                          rx_ferr == e.ferr && rx_brk == e.brk && rx_brk_len == e.blen, e.tag,
                          {rx_brk_len, rx_brk, rx_ferr, rx_perr, rx_word},
                          {e.blen, e.brk, e.ferr, e.perr, e.word});
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: all outputs clear after reset
        check({rx_valid, rx_word, rx_perr, rx_ferr, rx_brk, rx_brk_len, idle_pulse} == '0,
              "R9 reset outputs", {rx_valid, rx_word}, 0);

        // R5: short low glitch is rejected; R7: no idle before any character
        drive(1'b0, 4);
        drive(1'b1, 350);
        check(events == 0, "R5 glitch rejected / R7 not armed", events, 0);

        // R1 back-to-back characters, then R7 idle
        exp_char(14'h0A5, 0, 0, "R1 first");
        exp_char(14'h03C, 0, 0, "R1 back-to-back");
        exp_idle("R7 idle after 8N1");
        send(14'h0A5, 8, 0, 0, 0, 0);
        send(14'h03C, 8, 0, 0, 0, 0);
        drive(1'b1, 350);
        check(sb.size() == 0, "R7 idle seen", sb.size(), 0);

        // R3 even parity, R4 two stop bits, 14-bit words
        cfg_len = 4'd14; cfg_par = 2'b01; cfg_two_stop = 1'b1;
        exp_char(14'h2A5B, 0, 0, "R3 even ok");
        exp_char(14'h1234, 1, 0, "R3 even bad");
        exp_idle("R7 idle after 14E2");
        send(14'h2A5B, 14, 1, 1, 0, 0);
        send(14'h1234, 14, 1, 1, 1, 0);
        drive(1'b1, 350);

        // R3 odd parity, 7 bits
        cfg_len = 4'd7; cfg_par = 2'b10; cfg_two_stop = 1'b0;
        exp_char(14'h055, 0, 0, "R3 odd ok");
        exp_char(14'h02A, 1, 0, "R3 odd bad");
        exp_idle("R7 idle after 7O1");
        send(14'h055, 7, 2, 0, 0, 0);
        send(14'h02A, 7, 2, 0, 1, 0);
        drive(1'b1, 350);

        // R2 clamp low (3 -> 5) and high (15 -> 14); R3 code 11 means none
        cfg_len = 4'd3; cfg_par = 2'b11;
        exp_char(14'h013, 0, 0, "R2 clamp to 5");
        exp_idle("R7 idle after clamp5");
        send(14'h013, 5, 0, 0, 0, 0);
        drive(1'b1, 350);
        cfg_len = 4'd15; cfg_par = 2'b00;
        exp_char(14'h2C71, 0, 0, "R2 clamp to 14");
        exp_idle("R7 idle after clamp14");
        send(14'h2C71, 14, 0, 0, 0, 0);
        drive(1'b1, 350);

        // R4 framing errors with two stops and with one
        cfg_len = 4'd8; cfg_two_stop = 1'b1;
        exp_char(14'h081, 0, 1, "R4 second stop low");
        exp_idle("R7 idle after ferr2");
        send(14'h081, 8, 0, 1, 0, 1);
        drive(1'b1, 350);
        cfg_two_stop = 1'b0;
        exp_char(14'h07E, 0, 1, "R4 single stop low");
        exp_idle("R7 idle after ferr1");
        send(14'h07E, 8, 0, 0, 0, 1);
        drive(1'b1, 350);

        // R6 boundaries: zero word with good stop; zero word, odd parity, low stop
        exp_char(14'h000, 0, 0, "R6 zero word not break");
        exp_idle("R7 idle after zero");
        send(14'h000, 8, 0, 0, 0, 0);
        drive(1'b1, 350);
        cfg_par = 2'b10;
        exp_char(14'h000, 0, 1, "R6 high parity not break");
        exp_idle("R7 idle after zero odd");
        send(14'h000, 8, 2, 0, 0, 1);
        drive(1'b1, 350);

        // R6 break of three character times (8N1 = 160 ticks)
        cfg_par = 2'b00;
        exp_brk(8'd3, "R6 break length 3");
        exp_idle("R7 idle after break");
        drive(1'b0, 560);
        drive(1'b1, 350);

        // R6 short break in 5E2 framing
        cfg_len = 4'd5; cfg_par = 2'b01; cfg_two_stop = 1'b1;
        exp_brk(8'd1, "R6 break length 1");
        exp_idle("R7 idle after short break");
        drive(1'b0, 150);
        drive(1'b1, 350);

        // R8 glitch inside idle window restarts it
        cfg_len = 4'd8; cfg_par = 2'b00; cfg_two_stop = 1'b0;
        exp_char(14'h05A, 0, 0, "R8 char before glitch");
        exp_idle("R8 idle after restart");
        send(14'h05A, 8, 0, 0, 0, 0);
        drive(1'b1, 100);
        drive(1'b0, 4);
        drive(1'b1, 120);
        check(sb.size() == 1, "R8 idle held back", sb.size(), 1);
        drive(1'b1, 100);
        check(sb.size() == 0, "R8 idle after restart", sb.size(), 0);

        drive(1'b1, 50);
        check(sb.size() == 0, "R1 scoreboard drained", sb.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule